// File: doc/BRIEF.md
# NAND Command and Address Decoder

This block is the device-side front end of a small-page NAND memory. It watches the multiplexed 8-bit I/O bus together with the chip-enable, write-enable and the two latch strobes. A byte is taken on each write-enable rising edge that occurs while chip-enable is low. Depending on the strobes, that byte is treated as a command, an address byte or a data byte. The decoder tracks the command sequences and gathers address bytes into a start column and a page (row) address. When a sequence is complete, it hands a single operation request to a memory back end.

A page is 528 bytes. The first 512 are the main area and the last 16 (columns 512 to 527) form the spare area. A row address names one of 32768 pages, and an erase block is 32 pages. Three pointer commands choose where in the page register a read or program begins. The second-half pointer lasts for only one access. A busy input from the back end blocks everything except reset and status requests. Data bytes of a program sequence are passed straight through to the back end.

All inputs are taken to be synchronous to `clk`, and the write-enable edge is detected by sampling.

Top module: `nand_cmd_frontend`

## Requirements
- R1: A bus byte is captured only when `we_n` is seen rising while `ce_n` is low. It is a command when `cle` is high and `ale` is low, an address when `ale` is high and `cle` is low, and data when both are low. With both strobes high, or with `ce_n` high, the byte has no effect.
- R2: Address bytes for read and program arrive in this order: column, low row, high row. The row is formed as {high[6:0], low[7:0]}, so bit 7 of the high byte is ignored.
- R3: Any of 00h, 01h or 50h followed by three address bytes produces exactly one request with `op_kind` = 0 (read), carrying the start column and the row.
- R4: 80h, then three address bytes, then any number of data bytes, then 10h produces one request with `op_kind` = 1 (program). The data bytes come out on `din_byte` with a `din_valid` pulse, in order, and only while the program is waiting for its confirm code.
- R5: While `busy` is high, only FFh and 70h are acted on. Every other command and every address or data byte is ignored.
- R6: 00h selects start column = column byte. 01h selects start column = 256 + column byte. After one read or program that used the 01h pointer, the pointer returns to the 00h state.
- R7: 50h is honoured only while `spare_en_n` is low. It then gives start column = 512 + column byte bits [3:0], and that pointer stays in force until 00h, 01h or FFh. With `spare_en_n` high, 50h changes nothing.
- R8: 60h, then two row address bytes (low, high), then D0h produces one request with `op_kind` = 2 (erase), `op_col` = 0, and the row with bits [4:0] cleared.
- R9: A 10h that is not preceded by a complete program address phase is discarded without a request and the decoder returns to idle. The same holds for a D0h without a complete erase address phase, and for an unknown command code.
- R10: 70h issues `op_kind` = 3 (status). 90h issues `op_kind` = 4 (ID). FFh issues `op_kind` = 5 (reset) and also returns the pointer to the 00h state. All three abandon any sequence in progress and carry column and row 0.
- R11: While `rst` is asserted and right after it, `op_valid` and `din_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, byte taken on rising edge |
| cle | input | 1 | Command latch strobe |
| ale | input | 1 | Address latch strobe |
| io_in | input | 8 | Multiplexed bus byte |
| busy | input | 1 | Back end busy, filters commands |
| spare_en_n | input | 1 | Low allows the spare-area pointer command |
| op_valid | output | 1 | One-cycle request pulse |
| op_kind | output | 3 | Request kind: 0 read, 1 program, 2 erase, 3 status, 4 ID, 5 reset |
| op_col | output | 10 | Start column in the page register |
| op_row | output | 15 | Page address |
| din_valid | output | 1 | Program data byte pulse |
| din_byte | output | 8 | Program data byte |

## Verification
Reads are issued under all three pointer commands with different column bytes. This separates the 0, 256 and 512+low-nibble offsets, and the program that follows a second-half read shows whether the pointer fell back. Complete sequences are mixed with truncated ones, stray confirm codes, disabled spare commands, bytes strobed with chip enable high or with both strobes high, and traffic during busy. Each of these must leave no request behind. A high row byte with bit 7 set, an erase row that is not block-aligned, and data bytes dropped in the middle of a program under busy confirm the address forming, block alignment and data gating.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

    localparam int IO_W       = 8;
    localparam int COL_W      = 10;
    localparam int ROW_W      = 15;
    localparam int ROW_HI_W   = ROW_W - IO_W;
    localparam int BLK_LOG2   = 5;
    localparam int HALF_OFS   = 256;
    localparam int MAIN_BYTES = 512;
    localparam int SPARE_W    = 4;
    localparam int PAGE_BYTES = MAIN_BYTES + (1 << SPARE_W);

    localparam logic [IO_W-1:0] CODE_PTR_LOW   = 8'h00;
    localparam logic [IO_W-1:0] CODE_PTR_HIGH  = 8'h01;
    localparam logic [IO_W-1:0] CODE_PTR_SPARE = 8'h50;
    localparam logic [IO_W-1:0] CODE_PROG_SET  = 8'h80;
    localparam logic [IO_W-1:0] CODE_PROG_GO   = 8'h10;
    localparam logic [IO_W-1:0] CODE_ERASE_SET = 8'h60;
    localparam logic [IO_W-1:0] CODE_ERASE_GO  = 8'hD0;
    localparam logic [IO_W-1:0] CODE_STATUS    = 8'h70;
    localparam logic [IO_W-1:0] CODE_IDENT     = 8'h90;
    localparam logic [IO_W-1:0] CODE_RESET     = 8'hFF;

    typedef enum logic [1:0] {
        BEAT_CMD  = 2'd0,
        BEAT_ADDR = 2'd1,
        BEAT_DATA = 2'd2
    } beat_kind_e;

    typedef struct packed {
        logic            vld;
        beat_kind_e      kind;
        logic [IO_W-1:0] val;
    } beat_t;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_PROGRAM = 3'd1,
        OP_ERASE   = 3'd2,
        OP_STATUS  = 3'd3,
        OP_IDENT   = 3'd4,
        OP_RESET   = 3'd5
    } op_kind_e;

    typedef enum logic [1:0] {
        REG_LOW   = 2'd0,
        REG_HIGH  = 2'd1,
        REG_SPARE = 2'd2
    } region_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } op_t;

    function automatic logic [COL_W-1:0] start_col(region_e r, logic [IO_W-1:0] c);
        case (r)
            REG_HIGH:  return COL_W'(HALF_OFS) + COL_W'(c);
            REG_SPARE: return COL_W'(MAIN_BYTES) + COL_W'(c[SPARE_W-1:0]);
            default:   return COL_W'(c);
        endcase
    endfunction

    function automatic logic [ROW_W-1:0] block_base(logic [ROW_W-1:0] r);
        return {r[ROW_W-1:BLK_LOG2], BLK_LOG2'(0)};
    endfunction

    function automatic logic busy_ok(logic [IO_W-1:0] code);
        return (code == CODE_RESET) || (code == CODE_STATUS);
    endfunction

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler
    import nand_fe_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            cle,
    input  logic            ale,
    input  logic [IO_W-1:0] io_in,
    output beat_t           beat
);

    logic we_q;
    logic edge_hit;

    assign edge_hit = we_n && !we_q && !ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q <= 1'b1;
            beat <= '0;
        end else begin
            we_q     <= we_n;
            beat.val <= io_in;
            beat.vld <= 1'b0;
            beat.kind <= BEAT_DATA;
            if (edge_hit) begin
                unique case ({cle, ale})
                    2'b10: begin beat.vld <= 1'b1; beat.kind <= BEAT_CMD;  end
                    2'b01: begin beat.vld <= 1'b1; beat.kind <= BEAT_ADDR; end
                    2'b00: begin beat.vld <= 1'b1; beat.kind <= BEAT_DATA; end
                    default: beat.vld <= 1'b0;
                endcase
            end
        end
    end

    // R1: a write-enable pulse yields at most one beat, never two in a row
    assert_beat_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        beat.vld |=> !beat.vld);

endmodule

// File: rtl/nand_addr_collect.sv
module nand_addr_collect
    import nand_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             row_only,
    input  logic             take,
    input  logic [IO_W-1:0]  val,
    output logic [IO_W-1:0]  col_byte,
    output logic [ROW_W-1:0] row,
    output logic [1:0]       cnt
);

    logic [IO_W-1:0]     col_q;
    logic [IO_W-1:0]     rlo_q;
    logic [ROW_HI_W-1:0] rhi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            rlo_q <= '0;
            rhi_q <= '0;
            cnt   <= 2'd0;
        end else if (clear) begin
            cnt <= row_only ? 2'd1 : 2'd0;
            if (row_only) col_q <= '0;
        end else if (take) begin
            case (cnt)
                2'd0:    col_q <= val;
                2'd1:    rlo_q <= val;
                2'd2:    rhi_q <= val[ROW_HI_W-1:0];
                default: ;
            endcase
            if (cnt != 2'd3) cnt <= cnt + 2'd1;
        end
    end

    assign col_byte = col_q;
    assign row      = {rhi_q, rlo_q};

endmodule

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
    import nand_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  beat_t            beat,
    input  logic             busy,
    input  logic             spare_en_n,
    input  logic [IO_W-1:0]  col_byte,
    input  logic [ROW_W-1:0] row,
    input  logic [1:0]       cnt,
    output logic             clear,
    output logic             row_only,
    output logic             take,
    output logic             op_vld_q,
    output op_t              op_q,
    output logic             din_vld_q,
    output logic [IO_W-1:0]  din_q
);

    typedef enum logic [2:0] {
        S_IDLE, S_RD_ADDR, S_RD_FIRE, S_PG_ADDR, S_PG_DATA, S_ER_ADDR, S_ER_WAIT
    } state_e;

    state_e  state_q, state_nxt;
    region_e region_q, region_nxt;
    logic    op_set, din_set;
    op_t     op_nxt;
    logic    is_cmd, cmd_ok, is_addr, is_data;

    assign is_cmd  = beat.vld && (beat.kind == BEAT_CMD);
    assign cmd_ok  = is_cmd && (!busy || busy_ok(beat.val));
    assign is_addr = beat.vld && (beat.kind == BEAT_ADDR) && !busy;
    assign is_data = beat.vld && (beat.kind == BEAT_DATA) && !busy;

    always_comb begin
        state_nxt  = state_q;
        region_nxt = region_q;
        op_set     = 1'b0;
        op_nxt     = '{kind: OP_READ, col: '0, row: '0};
        din_set    = 1'b0;
        clear      = 1'b0;
        row_only   = 1'b0;
        take       = 1'b0;
        if (state_q == S_RD_FIRE) begin
            op_set     = 1'b1;
            op_nxt     = '{kind: OP_READ, col: start_col(region_q, col_byte), row: row};
            if (region_q == REG_HIGH) region_nxt = REG_LOW;
            state_nxt  = S_IDLE;
        end else if (cmd_ok) begin
            state_nxt = S_IDLE;
            case (beat.val)
                CODE_PTR_LOW: begin
                    region_nxt = REG_LOW;  clear = 1'b1; state_nxt = S_RD_ADDR;
                end
                CODE_PTR_HIGH: begin
                    region_nxt = REG_HIGH; clear = 1'b1; state_nxt = S_RD_ADDR;
                end
                CODE_PTR_SPARE: begin
                    if (!spare_en_n) begin
                        region_nxt = REG_SPARE; clear = 1'b1; state_nxt = S_RD_ADDR;
                    end else begin
                        state_nxt = state_q;
                    end
                end
                CODE_PROG_SET: begin
                    clear = 1'b1; state_nxt = S_PG_ADDR;
                end
                CODE_PROG_GO: begin
                    if (state_q == S_PG_DATA) begin
                        op_set = 1'b1;
                        op_nxt = '{kind: OP_PROGRAM, col: start_col(region_q, col_byte), row: row};
                        if (region_q == REG_HIGH) region_nxt = REG_LOW;
                    end
                end
                CODE_ERASE_SET: begin
                    clear = 1'b1; row_only = 1'b1; state_nxt = S_ER_ADDR;
                end
                CODE_ERASE_GO: begin
                    if (state_q == S_ER_WAIT) begin
                        op_set = 1'b1;
                        op_nxt = '{kind: OP_ERASE, col: '0, row: block_base(row)};
                    end
                end
                CODE_STATUS: begin
                    op_set = 1'b1; op_nxt.kind = OP_STATUS;
                end
                CODE_IDENT: begin
                    op_set = 1'b1; op_nxt.kind = OP_IDENT;
                end
                CODE_RESET: begin
                    op_set = 1'b1; op_nxt.kind = OP_RESET; region_nxt = REG_LOW;
                end
                default: ;
            endcase
        end else if (is_addr) begin
            case (state_q)
                S_RD_ADDR, S_PG_ADDR, S_ER_ADDR: begin
                    take = 1'b1;
                    if (cnt == 2'd2) begin
                        case (state_q)
                            S_RD_ADDR: state_nxt = S_RD_FIRE;
                            S_PG_ADDR: state_nxt = S_PG_DATA;
                            default:   state_nxt = S_ER_WAIT;
                        endcase
                    end
                end
                default: ;
            endcase
        end else if (is_data && state_q == S_PG_DATA) begin
            din_set = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            region_q  <= REG_LOW;
            op_vld_q  <= 1'b0;
            op_q      <= '{kind: OP_READ, col: '0, row: '0};
            din_vld_q <= 1'b0;
            din_q     <= '0;
        end else begin
            state_q   <= state_nxt;
            region_q  <= region_nxt;
            op_vld_q  <= op_set;
            din_vld_q <= din_set;
            if (op_set)  op_q  <= op_nxt;
            if (din_set) din_q <= beat.val;
        end
    end

    // R5: a blocked command during busy never produces a request
    assert_busy_filter_R5: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && busy && !busy_ok(beat.val)) |=> !op_vld_q);

    // R6: the second-half pointer is gone once its read has been issued
    assert_high_falls_back_R6: assert property (@(posedge clk) disable iff (rst)
        (op_vld_q && op_q.kind == OP_READ) |-> region_q != REG_HIGH);

    // R7: no start column lies outside the page register
    assert_col_in_page_R7: assert property (@(posedge clk) disable iff (rst)
        op_vld_q |-> op_q.col < COL_W'(PAGE_BYTES));

    // R8: erase requests are block aligned and carry column zero
    assert_erase_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        (op_vld_q && op_q.kind == OP_ERASE) |-> (op_q.row[BLK_LOG2-1:0] == '0 && op_q.col == '0));

    // R4: data pass-through only during the program data phase
    assert_din_in_program_R4: assert property (@(posedge clk) disable iff (rst)
        din_vld_q |-> (state_q == S_PG_DATA || state_q == S_IDLE));

endmodule

// File: rtl/nand_cmd_frontend.sv
module nand_cmd_frontend
    import nand_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             cle,
    input  logic             ale,
    input  logic [IO_W-1:0]  io_in,
    input  logic             busy,
    input  logic             spare_en_n,
    output logic             op_valid,
    output logic [2:0]       op_kind,
    output logic [COL_W-1:0] op_col,
    output logic [ROW_W-1:0] op_row,
    output logic             din_valid,
    output logic [IO_W-1:0]  din_byte
);

    beat_t            beat;
    logic             clear, row_only, take;
    logic [IO_W-1:0]  col_byte;
    logic [ROW_W-1:0] row;
    logic [1:0]       cnt;
    op_t              op;

    nand_bus_sampler u_sampler (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n),
        .cle(cle), .ale(ale), .io_in(io_in), .beat(beat)
    );

    nand_addr_collect u_addr (
        .clk(clk), .rst(rst), .clear(clear), .row_only(row_only),
        .take(take), .val(beat.val), .col_byte(col_byte), .row(row), .cnt(cnt)
    );

    nand_cmd_fsm u_fsm (
        .clk(clk), .rst(rst), .beat(beat), .busy(busy), .spare_en_n(spare_en_n),
        .col_byte(col_byte), .row(row), .cnt(cnt),
        .clear(clear), .row_only(row_only), .take(take),
        .op_vld_q(op_valid), .op_q(op), .din_vld_q(din_valid), .din_q(din_byte)
    );

    assign op_kind = op.kind;
    assign op_col  = op.col;
    assign op_row  = op.row;

endmodule

// File: tb/nand_cmd_frontend_tb.sv
module nand_cmd_frontend_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0;
    logic [7:0]  io_in = 8'h00;
    logic        busy = 1'b0, spare_en_n = 1'b0;
    logic        op_valid, din_valid;
    logic [2:0]  op_kind;
    logic [9:0]  op_col;
    logic [14:0] op_row;
    logic [7:0]  din_byte;

    int vectors = 0;
    int miscompares = 0;
    string cur_tag = "R11";

    logic [2:0]  exp_kind[$];
    logic [9:0]  exp_col[$];
    logic [14:0] exp_row[$];
    string       exp_tag[$];
    logic [7:0]  exp_din[$];
    string       din_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_cmd_frontend u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
        .io_in(io_in), .busy(busy), .spare_en_n(spare_en_n),
        .op_valid(op_valid), .op_kind(op_kind), .op_col(op_col), .op_row(op_row),
        .din_valid(din_valid), .din_byte(din_byte)
    );

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (op_valid) begin
                vectors++;
                if (exp_kind.size() == 0) begin
                    miscompares++;
                    $display("FAIL %s unexpected request kind=%0d col=%0d row=%0h, expected none",
                             cur_tag, op_kind, op_col, op_row);
                end else begin
                    automatic logic [2:0]  k = exp_kind.pop_front();
                    automatic logic [9:0]  c = exp_col.pop_front();
                    automatic logic [14:0] r = exp_row.pop_front();
                    automatic string       t = exp_tag.pop_front();
                    if (op_kind !== k || op_col !== c || op_row !== r) begin
                        miscompares++;
                        $display("FAIL %s request kind=%0d col=%0d row=%0h, expected kind=%0d col=%0d row=%0h",
                                 t, op_kind, op_col, op_row, k, c, r);
                    end
                end
            end
            if (din_valid) begin
                vectors++;
                if (exp_din.size() == 0) begin
                    miscompares++;
                    $display("FAIL %s unexpected data byte %0h, expected none", cur_tag, din_byte);
                end else begin
                    automatic logic [7:0] d = exp_din.pop_front();
                    automatic string      t = din_tag.pop_front();
                    if (din_byte !== d) begin
                        miscompares++;
                        $display("FAIL %s data byte %0h, expected %0h", t, din_byte, d);
                    end
                end
            end
        end
    end

    task automatic pulse(input logic ce_lo, input logic c, input logic a, input logic [7:0] b);
        @(negedge clk);
        ce_n = !ce_lo; cle = c; ale = a; io_in = b; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (2) @(negedge clk);
        cle = 1'b0; ale = 1'b0; ce_n = 1'b1;
    endtask

    task automatic cmd(input logic [7:0] b);  pulse(1'b1, 1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b);  pulse(1'b1, 1'b0, 1'b1, b); endtask
    task automatic dat(input logic [7:0] b);  pulse(1'b1, 1'b0, 1'b0, b); endtask

    task automatic expect_op(input logic [2:0] k, input logic [9:0] c, input logic [14:0] r, input string t);
        exp_kind.push_back(k); exp_col.push_back(c); exp_row.push_back(r); exp_tag.push_back(t);
    endtask

    task automatic expect_din(input logic [7:0] d, input string t);
        exp_din.push_back(d); din_tag.push_back(t);
    endtask

    task automatic drain(input string t);
        repeat (6) @(negedge clk);
        vectors++;
        if (exp_kind.size() != 0 || exp_din.size() != 0) begin
            miscompares++;
            $display("FAIL %s missing results: %0d requests and %0d data bytes outstanding, expected 0",
                     t, exp_kind.size(), exp_din.size());
            exp_kind.delete(); exp_col.delete(); exp_row.delete(); exp_tag.delete();
            exp_din.delete(); din_tag.delete();
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired, actual hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs quiet in reset and after it
        vectors++;
        if (op_valid !== 1'b0 || din_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R11 in reset op_valid=%b din_valid=%b, expected 0 0", op_valid, din_valid);
        end
        rst = 1'b0;
        @(negedge clk);
        vectors++;
        if (op_valid !== 1'b0 || din_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R11 after reset op_valid=%b din_valid=%b, expected 0 0", op_valid, din_valid);
        end

        // R2 R3: first-half read, high row byte bit 7 clear
        cur_tag = "R3";
        expect_op(3'd0, 10'd18, 15'h0534, "R3 first-half read");
        cmd(8'h00); adr(8'h12); adr(8'h34); adr(8'h05);
        drain("R3");

        // R6 R2: second-half read with bit 7 set in high row byte
        cur_tag = "R6";
        expect_op(3'd0, 10'd384, 15'h0100, "R6 second-half read / R2 row forming");
        cmd(8'h01); adr(8'h80); adr(8'h00); adr(8'h81);
        drain("R6");

        // R6 R4: pointer fell back, program uses first half; data passes through
        cur_tag = "R4";
        expect_din(8'hA5, "R4 data 0"); expect_din(8'h5A, "R4 data 1"); expect_din(8'h3C, "R4 data 2");
        expect_op(3'd1, 10'd5, 15'h0010, "R6 fallback / R4 program");
        cmd(8'h80); adr(8'h05); adr(8'h10); adr(8'h00);
        dat(8'hA5); dat(8'h5A); dat(8'h3C); cmd(8'h10);
        drain("R4");

        // R7: spare command disabled has no effect
        cur_tag = "R7";
        spare_en_n = 1'b1;
        cmd(8'h50); adr(8'h01); adr(8'h02); adr(8'h03);
        drain("R7 disabled spare command");
        expect_op(3'd1, 10'd7, 15'h0000, "R7 pointer unchanged by disabled spare command");
        cmd(8'h80); adr(8'h07); adr(8'h00); adr(8'h00); cmd(8'h10);
        drain("R7");

        // R7: spare read and sticky spare pointer on next program
        spare_en_n = 1'b0;
        expect_op(3'd0, 10'd523, 15'h0001, "R7 spare read");
        cmd(8'h50); adr(8'h2B); adr(8'h01); adr(8'h00);
        drain("R7 spare read");
        expect_op(3'd1, 10'd516, 15'h0002, "R7 spare pointer persists");
        cmd(8'h80); adr(8'h24); adr(8'h02); adr(8'h00); cmd(8'h10);
        drain("R7 persist");

        // R10: reset returns pointer to first half
        cur_tag = "R10";
        expect_op(3'd5, 10'd0, 15'h0000, "R10 reset request");
        cmd(8'hFF);
        expect_op(3'd1, 10'd36, 15'h0000, "R10 pointer back to first half");
        cmd(8'h80); adr(8'h24); adr(8'h00); adr(8'h00); cmd(8'h10);
        drain("R10");

        // R8: block erase, row aligned down
        cur_tag = "R8";
        expect_op(3'd2, 10'd0, 15'h0120, "R8 erase");
        cmd(8'h60); adr(8'h3F); adr(8'h01); cmd(8'hD0);
        drain("R8");

        // R9: misplaced confirms, short address phases, unknown code
        cur_tag = "R9";
        cmd(8'hD0);
        cmd(8'h80); adr(8'h01); adr(8'h02); cmd(8'h10);
        dat(8'h77);
        cmd(8'h60); adr(8'h05); cmd(8'hD0);
        cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'h33); cmd(8'h10);
        drain("R9");

        // R5: busy filtering of commands, address and data bytes
        cur_tag = "R5";
        busy = 1'b1;
        cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03);
        cmd(8'h60); cmd(8'h90);
        expect_op(3'd3, 10'd0, 15'h0000, "R5 status during busy");
        cmd(8'h70);
        expect_op(3'd5, 10'd0, 15'h0000, "R5 reset during busy");
        cmd(8'hFF);
        busy = 1'b0;
        adr(8'h09);
        drain("R5 busy commands");
        cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00);
        busy = 1'b1; dat(8'h11); busy = 1'b0;
        expect_din(8'h22, "R5 data after busy");
        expect_op(3'd1, 10'd0, 15'h0000, "R5 program after busy data");
        dat(8'h22); cmd(8'h10);
        drain("R5 busy data");

        // R10: ID and status while idle, status abandons a sequence
        cur_tag = "R10";
        expect_op(3'd4, 10'd0, 15'h0000, "R10 ID");
        cmd(8'h90);
        expect_op(3'd3, 10'd0, 15'h0000, "R10 status abandons read");
        cmd(8'h00); adr(8'h01); cmd(8'h70); adr(8'h02); adr(8'h03);
        drain("R10 ID/status");

        // R1: chip enable high, both strobes high, stray data in idle
        cur_tag = "R1";
        pulse(1'b0, 1'b1, 1'b0, 8'h90);
        pulse(1'b1, 1'b1, 1'b1, 8'h90);
        dat(8'h44);
        drain("R1 ignored bytes");
        expect_op(3'd0, 10'd255, 15'h7FFF, "R1 R2 read after ignored bytes, maximum row");
        cmd(8'h00); adr(8'hFF); adr(8'hFF); adr(8'hFF);
        drain("R1");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule